// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered DAC Code Register

This block is the digital front end of a 16-bit parallel-input digital-to-analog converter. A host builds the conversion code in two 8-bit staging registers. It can write them one byte at a time, or it can write both at once from a 16-bit bus. Each staging byte has its own active-low select. Both bytes share one active-low write strobe. A separate active-low load strobe copies the complete staged word into the 16-bit output register. That register's value is the code presented to the converter. If the load strobe is held low, the output register tracks the staging registers continuously.

The host strobes are asynchronous to the system clock. Every strobe and the data bus pass through two-flop synchronizers. The block counts each low window in clock cycles. A window shorter than the configured minimum is rejected and sets a sticky error flag. An active-low clear empties every register and overrides writes and loads. System reset also starts the block at zero. Whenever the output code changes, the block raises a single-cycle update pulse.

Top module: `dac_byte_front`

## Requirements
- R1: A write window for the low byte is the time both wr_n and cs_lo_n are low. It stores din[7:0] into the low staging byte. A write window for the high byte, with cs_hi_n, stores din[15:8] into the high staging byte. code_out bits 7:0 come from the low byte and bits 15:8 from the high byte.
- R2: A write takes effect only when its synchronized window ends. The stored value is the data sampled together with the window's last low sample. Data that changes in the same clock interval as the strobe rise is therefore not stored.
- R3: If wr_n, cs_lo_n and cs_hi_n are low together, a single window loads both staging bytes.
- R4: Writes leave code_out unchanged. Once the synchronized ld_n has been low for MIN_LOW_CYC cycles, code_out takes the full staged word.
- R5: While ld_n stays low past that point, code_out follows the staging registers. A byte commit reaches code_out on the same clock edge that stores it.
- R6: Once the synchronized clr_n has been low for MIN_LOW_CYC cycles, both staging bytes and code_out are zero. While clear is in force, a write that ends is discarded and a load has no effect.
- R7: While rst_n is low, code_out is zero, code_upd is low and width_err is low. The staging bytes are zero after reset.
- R8: A synchronized low window of 1 to MIN_LOW_CYC-1 cycles sets width_err. This applies to a write window of either byte, to ld_n and to clr_n. width_err stays set until reset, and the short window changes no register.
- R9: code_upd is high for exactly the cycles in which code_out has just taken a value different from the one it held in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Shared write strobe, active low, asynchronous |
| cs_lo_n | input | 1 | Low-byte select, active low, asynchronous |
| cs_hi_n | input | 1 | High-byte select, active low, asynchronous |
| ld_n | input | 1 | Load strobe to the output register, active low |
| clr_n | input | 1 | Clear of all registers, active low |
| din | input | 16 | Host data bus |
| code_out | output | 16 | Output register value (converter code) |
| code_upd | output | 1 | One-cycle pulse when code_out changes |
| width_err | output | 1 | Sticky flag for a too-short strobe window |

## Verification
Take a strobe level that is first sampled at clock edge k. After edges k and k+1 it is in the synchronized domain, and its effect is on the ports after edge k+2. Examples are a write commit on the rise of a window, a load becoming effective on the MIN_LOW_CYC-th low sample, or a clear taking hold. The reference model in the bench delays its inputs by the same two sample edges, with the data one sample older still. It compares code_out, code_upd and width_err at every falling edge, so each result is read a half cycle after the edge that produces it. The directed checks wait four cycles after each strobe edge before they read the settled code.

// File: rtl/dacf_pkg.sv
package dacf_pkg;
    parameter int BYTE_W = 8;
    parameter int WORD_W = 2 * BYTE_W;

    // pulse-width channels
    parameter int N_CH   = 4;
    parameter int CH_WLO = 0;
    parameter int CH_WHI = 1;
    parameter int CH_LD  = 2;
    parameter int CH_CLR = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [WORD_W-1:0] dac;
        logic [WORD_W-1:0] dprev;
        logic              upd;
        logic              err;
    } core_st_t;
endpackage

// File: rtl/dacf_sync2.sv
module dacf_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/dacf_width_meter.sv
module dacf_width_meter #(
    parameter int MIN_LOW_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic qual,
    output logic end_long,
    output logic end_short
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_LOW_CYC);
    localparam logic [CW-1:0] MIN_M1 = CW'(MIN_LOW_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (active) begin
            cnt_d = (cnt_q >= MIN_C) ? MIN_C : cnt_q + 1'b1;
        end
        qual      = active && (cnt_q >= MIN_M1);
        end_long  = !active && (cnt_q >= MIN_C);
        end_short = !active && (cnt_q != '0) && (cnt_q < MIN_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dacf_core.sv
module dacf_core
    import dacf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   qual,
    input  logic [N_CH-1:0]   end_long,
    input  logic [N_CH-1:0]   end_short,
    input  logic [WORD_W-1:0] dsync,
    output logic [WORD_W-1:0] code,
    output logic              upd,
    output logic              err,
    output logic [BYTE_W-1:0] lo_byte
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.dprev = dsync;
        st_d.err   = st_q.err | (|end_short);
        if (qual[CH_CLR]) begin
            st_d.lo  = '0;
            st_d.hi  = '0;
            st_d.dac = '0;
        end else begin
            if (end_long[CH_WLO]) st_d.lo = st_q.dprev[BYTE_W-1:0];
            if (end_long[CH_WHI]) st_d.hi = st_q.dprev[WORD_W-1:BYTE_W];
            if (qual[CH_LD])      st_d.dac = {st_d.hi, st_d.lo};
        end
        st_d.upd = (st_d.dac != st_q.dac);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code    = st_q.dac;
    assign upd     = st_q.upd;
    assign err     = st_q.err;
    assign lo_byte = st_q.lo;
endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
    import dacf_pkg::*;
#(
    parameter int MIN_LOW_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi_n,
    input  logic              ld_n,
    input  logic              clr_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] code_out,
    output logic              code_upd,
    output logic              width_err
);
    localparam int N_STB = 5;

    logic [N_STB-1:0]  stb_s;
    logic [WORD_W-1:0] din_s;
    logic [N_CH-1:0]   act_w, qual_w, end_long_w, end_short_w;
    logic [BYTE_W-1:0] lo_w;
    logic              unused_bits;

    // strobe order: {clr, ld, cs_hi, cs_lo, wr}
    dacf_sync2 #(.W(N_STB), .RST_VAL({N_STB{1'b1}})) u_stb_sync (
        .clk(clk), .rst_n(rst_n),
        .d({clr_n, ld_n, cs_hi_n, cs_lo_n, wr_n}), .q(stb_s)
    );

    dacf_sync2 #(.W(WORD_W), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
    );

    always_comb begin
        act_w[CH_WLO] = !stb_s[0] && !stb_s[1];
        act_w[CH_WHI] = !stb_s[0] && !stb_s[2];
        act_w[CH_LD]  = !stb_s[3];
        act_w[CH_CLR] = !stb_s[4];
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_meter
        dacf_width_meter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_meter (
            .clk(clk), .rst_n(rst_n), .active(act_w[g]),
            .qual(qual_w[g]), .end_long(end_long_w[g]), .end_short(end_short_w[g])
        );
    end

    dacf_core u_core (
        .clk(clk), .rst_n(rst_n),
        .qual(qual_w), .end_long(end_long_w), .end_short(end_short_w),
        .dsync(din_s),
        .code(code_out), .upd(code_upd), .err(width_err), .lo_byte(lo_w)
    );

    assign unused_bits = &{1'b0, qual_w[CH_WLO], qual_w[CH_WHI],
                           end_long_w[CH_LD], end_long_w[CH_CLR]};
endmodule

// File: rtl/dacf_chk.sv
module dacf_chk
    import dacf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] code_out,
    input logic              code_upd,
    input logic              width_err,
    input logic              clr_qual,
    input logic              ld_qual,
    input logic              lo_commit,
    input logic [BYTE_W-1:0] lo_byte
);
    // R9
    upd_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> (code_out != $past(code_out)));

    // R9
    quiet_means_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_upd |-> $stable(code_out));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |=> width_err);

    // R6
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_qual |=> (code_out == '0) && (lo_byte == '0));

    // R4
    no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_qual && !clr_qual) |=> $stable(code_out));

    // R2
    lo_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_commit && !clr_qual) |=> $stable(lo_byte));
endmodule

bind dac_byte_front dacf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .code_out(code_out), .code_upd(code_upd),
    .width_err(width_err), .clr_qual(qual_w[3]), .ld_qual(qual_w[2]),
    .lo_commit(end_long_w[0]), .lo_byte(lo_w)
);

// File: tb/dac_byte_front_tb_top.sv
module dac_byte_front_tb_top;
    localparam int MINW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, cs_lo_n = 1'b1, cs_hi_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [15:0] din = 16'h0;
    logic [15:0] code_out;
    logic        code_upd, width_err;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R7";

    // reference model state
    logic [4:0]  p1 = 5'h1f, p2 = 5'h1f;
    logic [15:0] dp1 = 0, dp2 = 0, dp3 = 0;
    int          run [4] = '{0, 0, 0, 0};
    logic [7:0]  m_lo = 0, m_hi = 0;
    logic [15:0] m_dac = 0;
    logic        m_upd = 0, m_err = 0;

    dac_byte_front #(.MIN_LOW_CYC(MINW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
        .ld_n(ld_n), .clr_n(clr_n), .din(din),
        .code_out(code_out), .code_upd(code_upd), .width_err(width_err)
    );

    always #10 clk = ~clk;

    // behavioural model: strobes seen two samples late, data three samples late
    always @(posedge clk) begin
        bit act [4];
        bit ok  [4];
        bit lng [4];
        bit sht [4];
        logic [7:0]  nlo, nhi;
        logic [15:0] ndac;
        if (!rst_n) begin
            p1 = 5'h1f; p2 = 5'h1f; dp1 = 0; dp2 = 0; dp3 = 0;
            for (int i = 0; i < 4; i++) run[i] = 0;
            m_lo = 0; m_hi = 0; m_dac = 0; m_upd = 0; m_err = 0;
        end else begin
            act[0] = !p2[0] && !p2[1];
            act[1] = !p2[0] && !p2[2];
            act[2] = !p2[3];
            act[3] = !p2[4];
            for (int i = 0; i < 4; i++) begin
                ok[i]  = act[i] && (run[i] + 1 >= MINW);
                lng[i] = !act[i] && (run[i] >= MINW);
                sht[i] = !act[i] && (run[i] > 0) && (run[i] < MINW);
                run[i] = act[i] ? run[i] + 1 : 0;
                if (sht[i]) m_err = 1'b1;
            end
            nlo = m_lo; nhi = m_hi; ndac = m_dac;
            if (ok[3]) begin
                nlo = 0; nhi = 0; ndac = 0;
            end else begin
                if (lng[0]) nlo = dp3[7:0];
                if (lng[1]) nhi = dp3[15:8];
                if (ok[2])  ndac = {nhi, nlo};
            end
            m_upd = (ndac != m_dac);
            m_lo = nlo; m_hi = nhi; m_dac = ndac;
            p2 = p1; p1 = {clr_n, ld_n, cs_hi_n, cs_lo_n, wr_n};
            dp3 = dp2; dp2 = dp1; dp1 = din;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (code_out !== m_dac) begin
                bad++;
                $display("FAIL %s code_out actual=%h expected=%h", tag, code_out, m_dac);
            end
            total++;
            if (code_upd !== m_upd) begin
                bad++;
                $display("FAIL R9 code_upd actual=%b expected=%b", code_upd, m_upd);
            end
            total++;
            if (width_err !== m_err) begin
                bad++;
                $display("FAIL %s width_err actual=%b expected=%b", tag, width_err, m_err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL %s watchdog actual=%0d expected=<100000", tag, cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_code(input string t, input logic [15:0] exp);
        total++;
        if (code_out !== exp) begin
            bad++;
            $display("FAIL %s direct code actual=%h expected=%h", t, code_out, exp);
        end
    endtask

    task automatic check_err(input string t, input logic exp);
        total++;
        if (width_err !== exp) begin
            bad++;
            $display("FAIL %s direct width_err actual=%b expected=%b", t, width_err, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // low window of len samples; data flips as the strobes rise
    task automatic do_write(input bit lo, input bit hi, input logic [15:0] v, input int len);
        @(negedge clk);
        din = v; wr_n = 1'b0; cs_lo_n = !lo; cs_hi_n = !hi;
        idle(len);
        wr_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1; din = ~v;
        idle(4);
    endtask

    task automatic ld_pulse(input int len);
        @(negedge clk); ld_n = 1'b0;
        idle(len);
        ld_n = 1'b1;
        idle(4);
    endtask

    task automatic clr_pulse(input int len);
        @(negedge clk); clr_n = 1'b0;
        idle(len);
        clr_n = 1'b1;
        idle(4);
    endtask

    initial begin
        idle(3);
        tag = "R7";
        check_code("R7", 16'h0000);
        check_err("R7", 1'b0);
        rst_n = 1'b1;
        idle(3);

        tag = "R4";
        do_write(1, 0, 16'h0034, 3);
        do_write(0, 1, 16'h1200, 3);
        check_code("R4", 16'h0000);
        ld_pulse(3);
        check_code("R1", 16'h1234);

        tag = "R3";
        do_write(1, 1, 16'hBEEF, 5);
        check_code("R4", 16'h1234);
        ld_pulse(3);
        check_code("R3", 16'hBEEF);

        tag = "R5";
        @(negedge clk); ld_n = 1'b0;
        idle(4);
        do_write(1, 0, 16'h00A5, 3);
        check_code("R5", 16'hBEA5);
        do_write(0, 1, 16'h5A00, 3);
        check_code("R5", 16'h5AA5);
        ld_n = 1'b1;
        idle(4);

        tag = "R2";
        do_write(1, 0, 16'h00C3, 4);
        ld_pulse(3);
        check_code("R2", 16'h5AC3);

        tag = "R8";
        check_err("R8", 1'b0);
        do_write(1, 1, 16'h1111, 2);
        check_err("R8", 1'b1);
        ld_pulse(3);
        check_code("R8", 16'h5AC3);
        do_write(1, 1, 16'h2222, 3);
        ld_pulse(2);
        check_code("R8", 16'h5AC3);
        clr_pulse(2);
        check_code("R8", 16'h5AC3);
        ld_pulse(3);
        check_code("R8", 16'h2222);

        tag = "R6";
        clr_pulse(3);
        check_code("R6", 16'h0000);
        ld_pulse(3);
        check_code("R6", 16'h0000);
        do_write(1, 1, 16'h3333, 3);
        @(negedge clk); clr_n = 1'b0;
        idle(4);
        ld_n = 1'b0;
        do_write(1, 1, 16'h7777, 3);
        check_code("R6", 16'h0000);
        clr_n = 1'b1;
        idle(4);
        check_code("R6", 16'h0000);
        ld_n = 1'b1;
        idle(4);

        tag = "R7";
        do_write(1, 1, 16'h4444, 3);
        ld_pulse(3);
        check_code("R1", 16'h4444);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check_code("R7", 16'h0000);
        check_err("R7", 1'b0);
        rst_n = 1'b1;
        idle(2);
        ld_pulse(3);
        check_code("R7", 16'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule